// File: doc/BRIEF.md
# Subroutine call and return controller

This block sequences the long absolute call, the return and the return-from-interrupt of an 8-bit microcontroller whose stack lives in byte-addressed data memory. When the core presents an instruction word with `start`, the block decodes it. A call assembles a 22-bit target from the instruction word and the word that follows it, then pushes a 16-bit return address as two bytes. A return pops two bytes and forms the next program counter from them.

The block owns the 16-bit stack pointer. It drives a single-byte data memory port and a next-PC load strobe. For return-from-interrupt it also raises a one-cycle request that sets the global interrupt enable, which is bit 7 of the status byte. Every accepted instruction keeps `busy` high for exactly four cycles. The new program counter is presented in the last of those cycles. The memory read path is combinational: `dm_rdata` answers `dm_addr` within the same cycle.

Top module: `call_ret_ctrl`

## Requirements
- R1: An instruction is accepted only when `start` is high and `busy` is low. The decode is a call when `opcode & 16'hFE0E == 16'h940E`, a return for `16'h9508`, and a return-from-interrupt for `16'h9518`. Any other opcode leaves `busy`, `sp` and the memory port untouched.
- R2: The call target is `{opcode[8:4], opcode[0], opnext[15:0]}`, so opcode bits 8:4 land in target bits 21:17, opcode bit 0 in target bit 16, and the second word in bits 15:0.
- R3: A call pushes `(pc_in + 2) & 16'hFFFF`. In the first busy cycle it writes the low byte at address `sp`. In the second busy cycle it writes the high byte at address `sp - 1`. After that, `sp` is reduced by 2.
- R4: A return adds 2 to `sp` in the first busy cycle. It then reads the high byte from the new `sp - 1` in the second busy cycle and the low byte from the new `sp` in the third. In the fourth cycle it presents `pc_next = {6'b0, high, low}`.
- R5: `gie_set` is high for one cycle, in the fourth busy cycle of a return-from-interrupt only. It stays low for call and for return.
- R6: `busy` is high for exactly four consecutive cycles per accepted instruction, and `pc_load` is high only in the fourth of them. A `start` that arrives while `busy` is high is ignored.
- R7: `sp` resets to the parameter `SP_INIT`. It changes only by ±2 per instruction and wraps modulo 2^16.
- R8: At most one byte is accessed per cycle: `dm_we` and `dm_re` are never both high, and both are low when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction word valid |
| opcode | input | 16 | First instruction word |
| opnext | input | 16 | Following program word (call target bits 15:0) |
| pc_in | input | 22 | Program counter of the instruction |
| busy | output | 1 | High during the four-cycle sequence |
| dm_we | output | 1 | Data memory byte write |
| dm_re | output | 1 | Data memory byte read |
| dm_addr | output | 16 | Data memory byte address |
| dm_wdata | output | 8 | Byte to write |
| dm_rdata | input | 8 | Byte read, valid in the same cycle |
| pc_load | output | 1 | Load `pc_next` into the program counter |
| pc_next | output | 22 | New program counter |
| gie_set | output | 1 | Set global interrupt enable |
| sp | output | 16 | Current stack pointer |

## Verification
A wrong stack pointer shows up in the next stack access. The write of a call goes to the wrong address in the first busy cycle, and the first read of a return goes to the wrong address in the second busy cycle. Because the bench runs nested calls and then unwinds them, a byte that was pushed in the wrong order or at the wrong address returns a wrong `pc_next` when the matching return reaches its fourth cycle. A state counter that skips or stalls shows up within one instruction as a `busy` window that is not four cycles long, or as a misplaced `pc_load`. The stack pointer is started near zero so that wrap-around is exercised in both directions.

// File: rtl/call_ret_ctrl.sv
module call_ret_ctrl #(
  parameter logic [15:0] SP_INIT = 16'h08FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] opcode,
  input  logic [15:0] opnext,
  input  logic [21:0] pc_in,
  output logic        busy,
  output logic        dm_we,
  output logic        dm_re,
  output logic [15:0] dm_addr,
  output logic [7:0]  dm_wdata,
  input  logic [7:0]  dm_rdata,
  output logic        pc_load,
  output logic [21:0] pc_next,
  output logic        gie_set,
  output logic [15:0] sp
);

  localparam logic [1:0] K_CALL = 2'd0;
  localparam logic [1:0] K_RET  = 2'd1;
  localparam logic [1:0] K_RETI = 2'd2;

  logic [2:0]  st;
  logic [1:0]  kind;
  logic [21:0] tgt;
  logic [15:0] ret_addr;
  logic [7:0]  hi_b, lo_b;

  wire is_call = (opcode & 16'hFE0E) == 16'h940E;
  wire is_ret  = opcode == 16'h9508;
  wire is_reti = opcode == 16'h9518;
  wire accept  = start && !busy && (is_call || is_ret || is_reti);
  wire popping = kind != K_CALL;
  wire [21:0] pc_plus2 = pc_in + 22'd2;

  assign busy    = st != 3'd0;
  assign pc_load = st == 3'd4;
  assign gie_set = pc_load && kind == K_RETI;
  assign pc_next = popping ? {6'd0, hi_b, lo_b} : tgt;

  always_comb begin
    dm_we    = 1'b0;
    dm_re    = 1'b0;
    dm_addr  = 16'd0;
    dm_wdata = 8'd0;
    if (!popping) begin
      if (st == 3'd1) begin
        dm_we    = 1'b1;
        dm_addr  = sp;
        dm_wdata = ret_addr[7:0];
      end else if (st == 3'd2) begin
        dm_we    = 1'b1;
        dm_addr  = sp - 16'd1;
        dm_wdata = ret_addr[15:8];
      end
    end else begin
      if (st == 3'd2) begin
        dm_re   = 1'b1;
        dm_addr = sp - 16'd1;
      end else if (st == 3'd3) begin
        dm_re   = 1'b1;
        dm_addr = sp;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= 3'd0;
      kind     <= K_CALL;
      tgt      <= 22'd0;
      ret_addr <= 16'd0;
      hi_b     <= 8'd0;
      lo_b     <= 8'd0;
      sp       <= SP_INIT;
    end else begin
      if (accept) begin
        st       <= 3'd1;
        kind     <= is_call ? K_CALL : (is_ret ? K_RET : K_RETI);
        tgt      <= {opcode[8:4], opcode[0], opnext};
        ret_addr <= pc_plus2[15:0];
      end else if (busy) begin
        st <= (st == 3'd4) ? 3'd0 : st + 3'd1;
      end
      if (st == 3'd1 && popping)  sp <= sp + 16'd2;
      if (st == 3'd2 && !popping) sp <= sp - 16'd2;
      if (st == 3'd2 && popping)  hi_b <= dm_rdata;
      if (st == 3'd3 && popping)  lo_b <= dm_rdata;
    end
  end

endmodule

// File: rtl/call_ret_ctrl_chk.sv
module call_ret_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        dm_we,
  input logic        dm_re,
  input logic        pc_load,
  input logic        gie_set,
  input logic [15:0] sp
);

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(dm_we && dm_re)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dm_we && !dm_re); // R8
  AST_LOAD_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> busy); // R6
  AST_LOAD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy); // R6
  AST_GIE_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    gie_set |-> pc_load); // R5
  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> (sp == $past(sp) + 16'd2) || (sp == $past(sp) - 16'd2)); // R7

endmodule

bind call_ret_ctrl call_ret_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .dm_we(dm_we), .dm_re(dm_re),
  .pc_load(pc_load), .gie_set(gie_set), .sp(sp)
);

// File: tb/sim_call_ret_ctrl.sv
module sim_call_ret_ctrl;
  localparam int PER = 10;
  localparam logic [15:0] SP0 = 16'h0002;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] opcode = 16'd0, opnext = 16'd0;
  logic [21:0] pc_in = 22'd0;
  logic busy, dm_we, dm_re, pc_load, gie_set;
  logic [15:0] dm_addr, sp;
  logic [7:0]  dm_wdata, dm_rdata;
  logic [21:0] pc_next;
  logic [7:0]  mem [256];

  int total = 0, bad = 0;
  logic [15:0] sp_m;
  logic [15:0] stk [16];
  int depth = 0;
  bit finished = 1'b0;

  always #(PER/2) clk = ~clk;

  call_ret_ctrl #(.SP_INIT(SP0)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .opnext(opnext),
    .pc_in(pc_in), .busy(busy), .dm_we(dm_we), .dm_re(dm_re), .dm_addr(dm_addr),
    .dm_wdata(dm_wdata), .dm_rdata(dm_rdata), .pc_load(pc_load),
    .pc_next(pc_next), .gie_set(gie_set), .sp(sp)
  );

  assign dm_rdata = mem[dm_addr[7:0]];
  always @(posedge clk) if (dm_we) mem[dm_addr[7:0]] <= dm_wdata;

  // opcode, opnext, pc
  localparam logic [53:0] VEC [6] = '{
    {16'h940E, 16'h1234, 22'h000100},
    {16'h95FF, 16'hFFFF, 22'h3FFFFE},
    {16'h941F, 16'hABCD, 22'h0012FE},
    {16'h9508, 16'h0000, 22'h000000},
    {16'h9518, 16'h0000, 22'h000000},
    {16'h9508, 16'h0000, 22'h000000}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] op, input logic [15:0] nx,
                     input logic [21:0] pc, input bit poke);
    bit          cl = ((op & 16'hFE0E) == 16'h940E);
    bit          rti = (op == 16'h9518);
    logic [21:0] ret22 = pc + 22'd2;
    logic [15:0] ra = ret22[15:0];
    logic [21:0] tg = {op[8:4], op[0], nx};
    logic [15:0] popv = 16'd0;
    if (!cl) begin
      depth--;
      popv = stk[depth];
    end
    @(negedge clk);
    opcode = op; opnext = nx; pc_in = pc; start = 1'b1;
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      if (c == 1 && poke) begin start = 1'b1; opcode = 16'h9508; end
      else start = 1'b0;
      chk(busy === 1'b1, "R6", $sformatf("busy cycle %0d", c), {31'd0, busy}, 1);
      chk(pc_load === (c == 4), "R6", $sformatf("pc_load cycle %0d", c), {31'd0, pc_load}, {31'd0, c == 4});
      chk(!(dm_we && dm_re), "R8", "single access", {30'd0, dm_we, dm_re}, 0);
      if (cl && c == 1) begin
        chk(dm_we && dm_addr == sp_m && dm_wdata == ra[7:0], "R3", "low byte push",
            {dm_we, 7'd0, dm_addr, dm_wdata}, {1'b1, 7'd0, sp_m, ra[7:0]});
      end
      if (cl && c == 2) begin
        chk(dm_we && dm_addr == sp_m - 16'd1 && dm_wdata == ra[15:8], "R3", "high byte push",
            {dm_we, 7'd0, dm_addr, dm_wdata}, {1'b1, 7'd0, sp_m - 16'd1, ra[15:8]});
      end
      if (!cl && c == 2) begin
        chk(dm_re && dm_addr == sp_m + 16'd1, "R4", "high byte read addr",
            {dm_re, 15'd0, dm_addr}, {1'b1, 15'd0, sp_m + 16'd1});
      end
      if (!cl && c == 3) begin
        chk(dm_re && dm_addr == sp_m + 16'd2, "R4", "low byte read addr",
            {dm_re, 15'd0, dm_addr}, {1'b1, 15'd0, sp_m + 16'd2});
      end
      if (c == 4) begin
        if (cl) chk(pc_next == tg, "R2", "call target", {10'd0, pc_next}, {10'd0, tg});
        else chk(pc_next == {6'd0, popv}, "R4", "return pc", {10'd0, pc_next}, {16'd0, popv});
        chk(gie_set === rti, "R5", "gie_set", {31'd0, gie_set}, {31'd0, rti});
      end
    end
    if (cl) begin
      stk[depth] = ra;
      depth++;
      sp_m = sp_m - 16'd2;
    end else begin
      sp_m = sp_m + 16'd2;
    end
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b0, "R6", "busy after four cycles", {31'd0, busy}, 0);
    chk(sp == sp_m, "R7", "sp after instruction", {16'd0, sp}, {16'd0, sp_m});
  endtask

  initial begin
    #(PER * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    sp_m = SP0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && pc_load === 1'b0 && gie_set === 1'b0, "R6", "reset idle",
        {29'd0, busy, pc_load, gie_set}, 0);
    chk(sp == SP0, "R7", "reset sp", {16'd0, sp}, {16'd0, SP0});
    chk(!dm_we && !dm_re, "R8", "reset quiet", {30'd0, dm_we, dm_re}, 0);

    // R1: a non-matching opcode (long jump, 0x940C) is ignored
    opcode = 16'h940C; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b0 && !dm_we && !dm_re, "R1", "jump opcode ignored",
        {29'd0, busy, dm_we, dm_re}, 0);
    chk(sp == SP0, "R1", "sp untouched", {16'd0, sp}, {16'd0, SP0});

    // R1 R2 R3 R4 R5 R7: walk the vector table
    foreach (VEC[i]) run(VEC[i][53:38], VEC[i][37:22], VEC[i][21:0], 1'b0);

    // R6: start while busy is ignored
    run(16'h940E, 16'h0042, 22'h000200, 1'b1);
    @(negedge clk);
    chk(busy === 1'b0 && sp == sp_m, "R6", "start during busy ignored",
        {15'd0, busy, sp}, {16'd0, sp_m});
    run(16'h9508, 16'h0000, 22'h000000, 1'b0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule